// File: doc/BRIEF.md
# Stereo Echo Filter and Feedback Mixer

Once per output sample this block runs the echo stage of a stereo synthesizer. It reads one stereo frame from a circular echo buffer in a 64 KB byte memory. It pushes that frame into an eight-deep history for each channel and filters the history with an 8-tap FIR that uses signed 8-bit coefficients. It then writes a new frame back to the same place in the buffer. The new frame is the dry echo send plus the filtered signal scaled by a feedback gain. The block also forms the final stereo output from the main voice sum and the filtered echo.

A sample starts with a one-cycle `start` pulse. A small sequencer then issues the four byte reads and the four byte writes one at a time. It raises `done` for one cycle when `out_l` and `out_r` hold the new sample. The buffer position starts at a page boundary chosen by `echo_page`. It steps through a buffer whose length is a multiple of 2048 bytes, and a new length takes effect only when the position is back at zero. The block is built for a 16-bit address space, 24-bit signed main and send sums and 16-bit outputs.

Top module: `echo_stage`

## Requirements
- R1: Each sample reads the four bytes at A, A+1, A+2 and A+3, where A = (echo_page*256 + offset) mod 65536. The bytes arrive in the order left low, left high, right low, right high, and each pair forms a little-endian signed 16-bit value.
- R2: The offset is 0 after reset and grows by 4 with each sample. It returns to 0 when the grown value is at least the buffer length. The length is echo_delay*2048 bytes and is reloaded only at a sample whose offset is 0. A delay of 0 keeps the offset at 0.
- R3: The FIR sum for a channel is the sum over k=0..7 of coef[k]*h[7-k]. Here coef[k] = signed fir_coef[8k+7:8k], h[0] is the frame read in this sample, and h[j] is the frame read j samples earlier. Tap 7 therefore weights the newest frame.
- R4: The write-back value is sat16((send >>> 7) + ((fir * fb_gain) >>> 14)), with fb_gain signed. It goes to the same four addresses in the same byte order as the read.
- R5: When echo_wr_off is high at start, no memory write occurs in that sample and the buffer bytes stay unchanged.
- R6: The output is sat16((main * main_vol + fir * echo_vol) >>> 14), with both volumes signed. sat16 clamps the result to the range -32768..32767.
- R7: When out_mute is high at start, out_l and out_r are 0 at done.
- R8: The left and right channels each have their own history, main sum, send sum and volumes. Changing one channel's inputs never alters the other channel's results.
- R9: Reset clears both histories, the offset, the outputs and done.
- R10: done is high for exactly one cycle per sample, after the last memory write. A start pulse that arrives while a sample is in progress is ignored.
- R11: Reads and writes wrap from address 0xFFFF to 0x0000 inside a frame and across frames.
- R12: The FIR sum keeps its full width. With all eight history entries at -32768, every coefficient at -128, main 0 and echo_vol -1, the output is exactly -2048.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins one sample when idle |
| echo_page | input | 8 | Page of the buffer start (address bits 15:8) |
| echo_delay | input | 4 | Buffer length in 2048-byte units |
| fir_coef | input | 64 | Eight signed taps, tap k at bits 8k+7:8k |
| fb_gain | input | 8 | Signed feedback gain |
| main_vol_l | input | 8 | Signed master volume, left |
| main_vol_r | input | 8 | Signed master volume, right |
| echo_vol_l | input | 8 | Signed echo volume, left |
| echo_vol_r | input | 8 | Signed echo volume, right |
| echo_wr_off | input | 1 | Suppresses the buffer write-back |
| out_mute | input | 1 | Forces the output to zero |
| main_l | input | 24 | Signed main voice sum, left |
| main_r | input | 24 | Signed main voice sum, right |
| send_l | input | 24 | Signed echo send sum, left |
| send_r | input | 24 | Signed echo send sum, right |
| mem_addr | output | 16 | Byte address for reads and writes |
| mem_rd | output | 1 | Read request; data expected on mem_rdata in the next cycle |
| mem_rdata | input | 8 | Read data |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| out_l | output | 16 | Output sample, left |
| out_r | output | 16 | Output sample, right |
| done | output | 1 | Output sample valid pulse |

## Verification
The hardest state to reach from the ports is a history holding eight known extreme frames together with a buffer position that has just wrapped. The position only moves one frame per sample, and the length changes only at offset zero. The bench therefore pre-fills whole buffer regions, runs long directed sequences and changes echo_delay while the offset is not zero. It also starts a buffer in page 0xFF so that address wrap is reached in fewer than 70 samples. A reset is applied in the middle of a run and followed by samples that weight only the oldest taps, which shows that the history was cleared.

// File: rtl/echo_pkg.sv
package echo_pkg;
  localparam int ACC_W = 48;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD, ST_CAP, ST_PUSH, ST_MIX, ST_WR, ST_DONE
  } seq_state_t;

  function automatic logic signed [15:0] sat16(input logic signed [ACC_W-1:0] v);
    if (v > 48'sd32767) return 16'sh7FFF;
    if (v < -48'sd32768) return 16'sh8000;
    return v[15:0];
  endfunction
endpackage

// File: rtl/echo_pos.sv
module echo_pos #(
  parameter int ADDR_W      = 16,
  parameter int DELAY_W     = 4,
  parameter int UNIT_BYTES  = 2048,
  parameter int FRAME_BYTES = 4,
  localparam int LEN_W      = DELAY_W + $clog2(UNIT_BYTES) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic [ADDR_W-9:0] page,
  input  logic [DELAY_W-1:0] delay,
  output logic [ADDR_W-1:0] base_q,
  output logic [LEN_W-1:0]  offset_q,
  output logic [LEN_W-1:0]  len_q
);
  logic [LEN_W-1:0] len_next;
  logic [LEN_W-1:0] off_inc;

  always_comb begin
    len_next = (offset_q == '0) ? (LEN_W'(delay) << $clog2(UNIT_BYTES)) : len_q;
    off_inc  = offset_q + LEN_W'(FRAME_BYTES);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      offset_q <= '0;
      len_q    <= '0;
      base_q   <= '0;
    end else if (step) begin
      base_q   <= {page, 8'h00} + ADDR_W'(offset_q);
      len_q    <= len_next;
      offset_q <= (off_inc >= len_next) ? '0 : off_inc;
    end
  end
endmodule

// File: rtl/echo_hist.sv
module echo_hist #(
  parameter int TAPS     = 8,
  parameter int SAMPLE_W = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic signed [SAMPLE_W-1:0] din,
  output logic signed [SAMPLE_W-1:0] hist [TAPS]
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < TAPS; i++) hist[i] <= '0;
    end else if (push) begin
      hist[0] <= din;
      for (int i = 1; i < TAPS; i++) hist[i] <= hist[i-1];
    end
  end
endmodule

// File: rtl/echo_fir.sv
module echo_fir #(
  parameter int TAPS     = 8,
  parameter int SAMPLE_W = 16,
  parameter int COEF_W   = 8,
  localparam int FIR_W   = SAMPLE_W + COEF_W + $clog2(TAPS)
) (
  input  logic signed [SAMPLE_W-1:0] hist [TAPS],
  input  logic [TAPS*COEF_W-1:0]     coef,
  output logic signed [FIR_W-1:0]    sum
);
  logic signed [FIR_W-1:0] prod [TAPS];

  // tap k weights the entry that is TAPS-1-k samples old from the newest end
  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    logic signed [COEF_W-1:0] c;
    assign c       = coef[k*COEF_W +: COEF_W];
    assign prod[k] = FIR_W'(hist[TAPS-1-k]) * FIR_W'(c);
  end

  always_comb begin
    sum = '0;
    for (int k = 0; k < TAPS; k++) sum = sum + prod[k];
  end
endmodule

// File: rtl/echo_stage.sv
module echo_stage #(
  parameter int ADDR_W   = 16,
  parameter int DELAY_W  = 4,
  parameter int TAPS     = 8,
  parameter int SAMPLE_W = 16,
  parameter int COEF_W   = 8,
  parameter int SUM_W    = 24,
  localparam int FIR_W   = SAMPLE_W + COEF_W + $clog2(TAPS),
  localparam int LEN_W   = DELAY_W + 11 + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [ADDR_W-9:0]        echo_page,
  input  logic [DELAY_W-1:0]       echo_delay,
  input  logic [TAPS*COEF_W-1:0]   fir_coef,
  input  logic [COEF_W-1:0]        fb_gain,
  input  logic [COEF_W-1:0]        main_vol_l,
  input  logic [COEF_W-1:0]        main_vol_r,
  input  logic [COEF_W-1:0]        echo_vol_l,
  input  logic [COEF_W-1:0]        echo_vol_r,
  input  logic                     echo_wr_off,
  input  logic                     out_mute,
  input  logic [SUM_W-1:0]         main_l,
  input  logic [SUM_W-1:0]         main_r,
  input  logic [SUM_W-1:0]         send_l,
  input  logic [SUM_W-1:0]         send_r,
  output logic [ADDR_W-1:0]        mem_addr,
  output logic                     mem_rd,
  input  logic [7:0]               mem_rdata,
  output logic                     mem_we,
  output logic [7:0]               mem_wdata,
  output logic [SAMPLE_W-1:0]      out_l,
  output logic [SAMPLE_W-1:0]      out_r,
  output logic                     done
);
  import echo_pkg::*;

  localparam int NCH         = 2;
  localparam int FRAME_BYTES = 2 * NCH;

  seq_state_t state_q;
  logic [1:0] idx_q;
  logic [7:0] frame_q [FRAME_BYTES];
  logic       wr_off_q, mute_q;

  // named internal events used by the checker
  logic                step;
  logic                push;
  logic                mix;
  logic [ADDR_W-1:0]   base_q;
  logic [LEN_W-1:0]    offset_q;
  logic [LEN_W-1:0]    len_q;

  logic signed [SAMPLE_W-1:0] new_smp [NCH];
  logic signed [FIR_W-1:0]    fir_sum [NCH];
  logic signed [SAMPLE_W-1:0] wb_q    [NCH];

  assign step = (state_q == ST_IDLE) && start;
  assign push = (state_q == ST_PUSH);
  assign mix  = (state_q == ST_MIX);

  echo_pos #(.ADDR_W(ADDR_W), .DELAY_W(DELAY_W), .UNIT_BYTES(2048),
             .FRAME_BYTES(FRAME_BYTES)) u_pos (
    .clk(clk), .rst_n(rst_n), .step(step), .page(echo_page),
    .delay(echo_delay), .base_q(base_q), .offset_q(offset_q), .len_q(len_q)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic signed [SAMPLE_W-1:0] hist [TAPS];
    assign new_smp[ch] = {frame_q[2*ch+1], frame_q[2*ch]};
    echo_hist #(.TAPS(TAPS), .SAMPLE_W(SAMPLE_W)) u_hist (
      .clk(clk), .rst_n(rst_n), .push(push), .din(new_smp[ch]), .hist(hist)
    );
    echo_fir #(.TAPS(TAPS), .SAMPLE_W(SAMPLE_W), .COEF_W(COEF_W)) u_fir (
      .hist(hist), .coef(fir_coef), .sum(fir_sum[ch])
    );
  end

  function automatic logic signed [SAMPLE_W-1:0] calc_wb(
    input logic signed [SUM_W-1:0]  send,
    input logic signed [FIR_W-1:0]  fir,
    input logic signed [COEF_W-1:0] fb
  );
    logic signed [ACC_W-1:0] dry, wet;
    dry = ACC_W'(send) >>> 7;
    wet = (ACC_W'(fir) * ACC_W'(fb)) >>> 14;
    return sat16(dry + wet);
  endfunction

  function automatic logic signed [SAMPLE_W-1:0] calc_out(
    input logic signed [SUM_W-1:0]  main_s,
    input logic signed [COEF_W-1:0] mvol,
    input logic signed [FIR_W-1:0]  fir,
    input logic signed [COEF_W-1:0] evol
  );
    logic signed [ACC_W-1:0] acc;
    acc = ACC_W'(main_s) * ACC_W'(mvol) + ACC_W'(fir) * ACC_W'(evol);
    return sat16(acc >>> 14);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      wr_off_q <= 1'b0;
      mute_q   <= 1'b0;
      out_l    <= '0;
      out_r    <= '0;
      for (int i = 0; i < FRAME_BYTES; i++) frame_q[i] <= '0;
      for (int c = 0; c < NCH; c++) wb_q[c] <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start) begin
          wr_off_q <= echo_wr_off;
          mute_q   <= out_mute;
          idx_q    <= '0;
          state_q  <= ST_RD;
        end
        ST_RD: state_q <= ST_CAP;
        ST_CAP: begin
          frame_q[idx_q] <= mem_rdata;
          if (idx_q == 2'(FRAME_BYTES - 1)) begin
            state_q <= ST_PUSH;
          end else begin
            idx_q   <= idx_q + 2'd1;
            state_q <= ST_RD;
          end
        end
        ST_PUSH: state_q <= ST_MIX;
        ST_MIX: begin
          wb_q[0] <= calc_wb(send_l, fir_sum[0], fb_gain);
          wb_q[1] <= calc_wb(send_r, fir_sum[1], fb_gain);
          out_l   <= mute_q ? '0 : calc_out(main_l, main_vol_l, fir_sum[0], echo_vol_l);
          out_r   <= mute_q ? '0 : calc_out(main_r, main_vol_r, fir_sum[1], echo_vol_r);
          idx_q   <= '0;
          state_q <= wr_off_q ? ST_DONE : ST_WR;
        end
        ST_WR: begin
          if (idx_q == 2'(FRAME_BYTES - 1)) state_q <= ST_DONE;
          else idx_q <= idx_q + 2'd1;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  logic [2*NCH*8-1:0] wb_bytes;
  assign wb_bytes  = {wb_q[1], wb_q[0]};
  assign mem_rd    = (state_q == ST_RD);
  assign mem_we    = (state_q == ST_WR);
  assign mem_addr  = base_q + ADDR_W'(idx_q);
  assign mem_wdata = wb_bytes[idx_q*8 +: 8];
  assign done      = (state_q == ST_DONE);
endmodule

// File: rtl/echo_chk.sv
module echo_chk #(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_rd,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [ADDR_W-1:0] base_q,
  input logic              done,
  input logic              mute_q,
  input logic              wr_off_q,
  input logic              step,
  input logic [LEN_W-1:0]  offset_q,
  input logic [LEN_W-1:0]  len_q,
  input logic [15:0]       out_l,
  input logic [15:0]       out_r
);
  logic [ADDR_W-1:0] rel;
  assign rel = mem_addr - base_q;

  p_single_access_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_we));

  p_addr_in_frame_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_we) |-> (rel < ADDR_W'(4)));

  p_offset_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (offset_q == '0) || (offset_q == $past(offset_q) + LEN_W'(4)));

  p_offset_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(offset_q));

  p_offset_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (len_q != '0) |-> (offset_q < len_q));

  p_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !wr_off_q);

  p_mute_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mute_q) |-> (out_l == '0 && out_r == '0));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind echo_stage echo_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_rd(mem_rd), .mem_we(mem_we),
  .mem_addr(mem_addr), .base_q(base_q), .done(done), .mute_q(mute_q),
  .wr_off_q(wr_off_q), .step(step), .offset_q(offset_q), .len_q(len_q),
  .out_l(out_l), .out_r(out_r)
);

// File: tb/tb_echo_stage.sv
module tb_echo_stage;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  echo_page = 8'h00;
  logic [3:0]  echo_delay = 4'd0;
  logic [63:0] fir_coef = '0;
  logic [7:0]  fb_gain = '0, main_vol_l = '0, main_vol_r = '0, echo_vol_l = '0, echo_vol_r = '0;
  logic        echo_wr_off = 1'b0, out_mute = 1'b0;
  logic [23:0] main_l = '0, main_r = '0, send_l = '0, send_r = '0;
  logic [15:0] mem_addr;
  logic        mem_rd, mem_we, done;
  logic [7:0]  mem_rdata = '0;
  logic [7:0]  mem_wdata;
  logic [15:0] out_l, out_r;

  int tests = 0, fails = 0;

  echo_stage dut (
    .clk(clk), .rst_n(rst_n), .start(start), .echo_page(echo_page),
    .echo_delay(echo_delay), .fir_coef(fir_coef), .fb_gain(fb_gain),
    .main_vol_l(main_vol_l), .main_vol_r(main_vol_r),
    .echo_vol_l(echo_vol_l), .echo_vol_r(echo_vol_r),
    .echo_wr_off(echo_wr_off), .out_mute(out_mute),
    .main_l(main_l), .main_r(main_r), .send_l(send_l), .send_r(send_r),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata),
    .mem_we(mem_we), .mem_wdata(mem_wdata),
    .out_l(out_l), .out_r(out_r), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // sparse byte memory, unwritten bytes follow a fixed address pattern
  logic [7:0] mem [int];
  int wr_count, rd_count, done_count;
  logic [15:0] rd_addr [4];

  function automatic logic [7:0] byte_at(int a);
    if (mem.exists(a)) return mem[a];
    return 8'(a * 37 + 11);
  endfunction

  always @(negedge clk) begin
    if (mem_rd) begin
      mem_rdata = byte_at(int'(mem_addr));
      if (rd_count < 4) rd_addr[rd_count] = mem_addr;
      rd_count++;
    end
    if (mem_we) begin
      mem[int'(mem_addr)] = mem_wdata;
      wr_count++;
    end
    if (done) done_count++;
  end

  // reference model state
  int ref_off, ref_len;
  longint h_l [8], h_r [8];

  function automatic longint sat(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic longint s8(logic [7:0] b);
    return longint'($signed(b));
  endfunction

  function automatic longint s24(logic [23:0] b);
    return longint'($signed(b));
  endfunction

  function automatic longint rd16(int a);
    logic [15:0] w;
    w = {byte_at((a + 1) & 16'hFFFF), byte_at(a & 16'hFFFF)};
    return longint'($signed(w));
  endfunction

  function automatic longint fir_of(longint h [8]);
    longint acc = 0;
    for (int j = 0; j < 8; j++) acc += s8(fir_coef[8*(7-j) +: 8]) * h[j];
    return acc;
  endfunction

  task automatic check(bit ok, string tag, longint act, longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    ref_off = 0; ref_len = 0;
    for (int i = 0; i < 8; i++) begin h_l[i] = 0; h_r[i] = 0; end
  endtask

  task automatic run_sample(bit busy_poke);
    int a, wd;
    longint fl, fr, wl, wr, ol, or_, pre [4];
    if (ref_off == 0) ref_len = int'(echo_delay) * 2048;
    a = (int'(echo_page) * 256 + ref_off) & 16'hFFFF;
    ref_off += 4;
    if (ref_off >= ref_len) ref_off = 0;
    for (int i = 7; i > 0; i--) begin h_l[i] = h_l[i-1]; h_r[i] = h_r[i-1]; end
    h_l[0] = rd16(a);
    h_r[0] = rd16(a + 2);
    for (int i = 0; i < 4; i++) pre[i] = longint'(byte_at((a + i) & 16'hFFFF));
    fl = fir_of(h_l); fr = fir_of(h_r);
    wl = sat((s24(send_l) >>> 7) + ((fl * s8(fb_gain)) >>> 14));
    wr = sat((s24(send_r) >>> 7) + ((fr * s8(fb_gain)) >>> 14));
    ol = out_mute ? 0 : sat((s24(main_l) * s8(main_vol_l) + fl * s8(echo_vol_l)) >>> 14);
    or_ = out_mute ? 0 : sat((s24(main_r) * s8(main_vol_r) + fr * s8(echo_vol_r)) >>> 14);
    wr_count = 0; rd_count = 0; done_count = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = busy_poke;
    @(negedge clk); start = 1'b0;
    wd = 0;
    while (!done && wd < 100) begin @(negedge clk); wd++; end
    check(done == 1'b1, "R10 done seen", done, 1);
    check($signed(out_l) == ol, "R6/R3 out_l", longint'($signed(out_l)), ol);
    check($signed(out_r) == or_, "R8/R6 out_r", longint'($signed(out_r)), or_);
    check(rd_addr[0] == 16'(a) && rd_addr[3] == 16'(a + 3), "R1/R2/R11 read address",
          longint'(rd_addr[0]), longint'(a));
    if (echo_wr_off) begin
      check(wr_count == 0, "R5 writes", wr_count, 0);
      check(longint'(byte_at(a)) == pre[0] && longint'(byte_at((a + 3) & 16'hFFFF)) == pre[3],
            "R5 buffer unchanged", longint'(byte_at(a)), pre[0]);
    end else begin
      check(rd16(a) == wl, "R4 write-back left", rd16(a), wl);
      check(rd16(a + 2) == wr, "R4/R8 write-back right", rd16(a + 2), wr);
    end
    @(negedge clk); @(negedge clk);
    check(done_count == 1 && !done, "R10 single done pulse", done_count, 1);
  endtask

  task automatic randomize_regs(bit flags);
    fir_coef   = {$urandom, $urandom};
    fb_gain    = 8'($urandom); main_vol_l = 8'($urandom); main_vol_r = 8'($urandom);
    echo_vol_l = 8'($urandom); echo_vol_r = 8'($urandom);
    main_l = 24'($urandom); main_r = 24'($urandom);
    send_l = 24'($urandom); send_r = 24'($urandom);
    echo_wr_off = flags && ($urandom % 4 == 0);
    out_mute    = flags && ($urandom % 4 == 0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7331));
    model_reset();
    repeat (3) @(negedge clk);
    // R9: reset state
    check(out_l == 0 && out_r == 0, "R9 reset outputs", longint'(out_l), 0);
    check(done == 0, "R9 reset done", done, 0);
    rst_n = 1'b1;

    // R2: one full buffer of 2048 bytes and past its wrap
    echo_page = 8'h20; echo_delay = 4'd1;
    for (int n = 0; n < 520; n++) begin randomize_regs(1'b1); run_sample(1'b0); end

    // R2: length change while offset is non-zero waits for the wrap
    echo_delay = 4'd2;
    for (int n = 0; n < 20; n++) begin randomize_regs(1'b0); run_sample(1'b0); end
    echo_delay = 4'd1;
    for (int n = 0; n < 1040; n++) begin randomize_regs(1'b1); run_sample(1'b0); end

    // R2: delay zero pins the offset
    echo_delay = 4'd0;
    for (int n = 0; n < 6; n++) begin randomize_regs(1'b1); run_sample(1'b0); end

    // R11: page 0xFF wraps through address zero
    do_reset();
    echo_page = 8'hFF; echo_delay = 4'd2;
    for (int n = 0; n < 80; n++) begin randomize_regs(1'b1); run_sample(1'b0); end

    // R6/R4 saturation corners
    randomize_regs(1'b0);
    main_l = 24'h7FFFFF; main_vol_l = 8'd127; main_r = 24'h800000; main_vol_r = 8'd127;
    send_l = 24'h7FFFFF; send_r = 24'h800000; fb_gain = 8'd0;
    run_sample(1'b0);

    // R7 mute and R5 inhibit together, R10 start while busy
    randomize_regs(1'b0); out_mute = 1'b1; echo_wr_off = 1'b1;
    run_sample(1'b1);
    randomize_regs(1'b0);
    run_sample(1'b1);

    // R9: mid-run reset clears history; only oldest taps weighted
    do_reset();
    echo_page = 8'h30; echo_delay = 4'd1;
    randomize_regs(1'b0);
    fir_coef = 64'h0000_0000_007F_7F7F; echo_vol_l = 8'd127; echo_vol_r = 8'd127;
    main_l = '0; main_r = '0;
    run_sample(1'b0);
    check($signed(out_l) == 0, "R9 history cleared", longint'($signed(out_l)), 0);

    // R12: full-scale FIR without wrap
    do_reset();
    echo_page = 8'h40; echo_delay = 4'd1;
    for (int i = 0; i < 64; i += 2) begin mem[16'h4000 + i] = 8'h00; mem[16'h4001 + i] = 8'h80; end
    randomize_regs(1'b0);
    fir_coef = {8{8'h80}}; echo_vol_l = 8'hFF; echo_vol_r = 8'hFF;
    main_l = '0; main_r = '0; echo_wr_off = 1'b1; out_mute = 1'b0;
    for (int n = 0; n < 8; n++) run_sample(1'b0);
    check($signed(out_l) == -2048, "R12 full width left", longint'($signed(out_l)), -2048);
    check($signed(out_r) == -2048, "R12 full width right", longint'($signed(out_r)), -2048);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule